// File: doc/BRIEF.md
# Context-Restoring Return Stack

This block is a private last-in, first-out store for a control-flow monitor that sits next to a processor core. It lives entirely inside the monitor, and no load or store issued by the core can reach it. When the checker accepts a call, it pushes one entry into the stack. The entry holds three fields: the return address, the identifier of the calling enforcement machine, and the state that machine must resume in.

When the checker sees a return, it pops the top entry. In the same cycle the block does three things. It compares the saved return address with the next PC reported by the core. It drives the saved machine and state identifiers out, so the checker can reload its context. It raises a mismatch flag if the addresses differ.

The block also flags three illegal requests, and each of them counts as a violation:
- a pop from an empty stack,
- a push onto a full stack,
- a push and a pop requested in the same cycle.

An illegal request leaves the stored contents untouched. Deciding whether a call or a return is legal in the first place is the checker's job, not this block's.

Top module: `ret_ctx_stack`

## Requirements
- R1: After reset the depth is 0, and the outputs mismatch, overflow, underflow, clash, violation and restore-valid are all low while no request is applied.
- R2: A push alone on a non-full stack stores {return address, machine ID, state ID} and raises the depth by one at the next clock edge. A stack holding DEPTH entries is full.
- R3: A pop alone on a non-empty stack sets restore-valid high in the same cycle and presents the most recently pushed machine ID and state ID that have not yet been popped (last-in, first-out order). The depth falls by one at the next clock edge.
- R4: On a valid pop, the mismatch flag and the violation flag are high in that cycle when the saved return address differs from the observed next PC in bits ADDR_W-1 down to CMP_LSB. The entry is still removed.
- R5: On a valid pop whose saved address equals the observed next PC in the compared bits, mismatch and violation stay low.
- R6: A pop alone on an empty stack raises underflow and violation in that cycle, keeps restore-valid low, and the depth stays 0.
- R7: A push alone on a full stack raises overflow and violation in that cycle. The depth stays DEPTH and the stored entries are unchanged.
- R8: A push and a pop requested together raise clash and violation in that cycle, and neither the depth nor the stored entries change.
- R9: Bits below CMP_LSB never take part in the address comparison. With CMP_LSB = 1, a next PC that differs from the saved address only in bit 0 gives no mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset that empties the stack |
| push_i | input | 1 | Push request for an accepted call |
| push_ret_addr_i | input | ADDR_W | Return address to save |
| push_mach_i | input | MACH_W | Caller machine ID to save |
| push_state_i | input | STATE_W | Return state ID to save |
| pop_i | input | 1 | Pop request for an observed return |
| pop_next_pc_i | input | ADDR_W | Next PC reported by the core on the return |
| rst_valid_o | output | 1 | Restored IDs are valid this cycle |
| rst_mach_o | output | MACH_W | Machine ID to restore |
| rst_state_o | output | STATE_W | State ID to restore |
| mismatch_o | output | 1 | Saved return address differs from the next PC |
| overflow_o | output | 1 | Push onto a full stack |
| underflow_o | output | 1 | Pop from an empty stack |
| clash_o | output | 1 | Push and pop requested together |
| violation_o | output | 1 | Any of the four error conditions |
| depth_o | output | $clog2(DEPTH+1) | Number of entries held |

## Verification
The stack is filled to capacity with entries whose fields are arithmetic functions of their slot. It is then drained, so a swapped slot or a broken last-in, first-out order shows up as a wrong machine or state value. Every level is popped once with a matching next PC and once with a single flipped address bit. This separates a correct comparator from one that always or never fires, and shows that a mismatching pop still removes its entry.

Pops on an empty stack, pushes on a full one, and simultaneous requests are applied at both ends and in the middle. The bench then pops again and checks that depth and contents were left intact. A second instance with the low address bit excluded confirms that bit 0 alone never raises a mismatch, while bit 1 still does.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   typedef enum logic [1:0] {
      RCS_IDLE  = 2'd0,
      RCS_PUSH  = 2'd1,
      RCS_POP   = 2'd2,
      RCS_CLASH = 2'd3
   } rcs_op_e;

   function automatic rcs_op_e rcs_classify(input logic push, input logic pop);
      rcs_op_e op;
      unique case ({push, pop})
         2'b10:   op = RCS_PUSH;
         2'b01:   op = RCS_POP;
         2'b11:   op = RCS_CLASH;
         default: op = RCS_IDLE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/rcs_ptr.sv
module rcs_ptr #(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grow,
   input  logic             shrink,
   output logic [CNT_W-1:0] cnt,
   output logic             empty,
   output logic             full
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (grow && !shrink)
         cnt <= cnt + 1'b1;
      else if (shrink && !grow)
         cnt <= cnt - 1'b1;
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_MAX);

endmodule

// File: rtl/rcs_store.sv
module rcs_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 42,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            slot[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < DEPTH; k++)
         if (rd_idx == IDX_W'(k))
            rd_data = slot[k];
   end

endmodule

// File: rtl/rcs_cmp.sv
module rcs_cmp #(
   parameter int ADDR_W  = 32,
   parameter int CMP_LSB = 0
) (
   input  logic [ADDR_W-1:0] saved,
   input  logic [ADDR_W-1:0] seen,
   output logic              differ
);

   if (CMP_LSB == 0) begin : g_full
      assign differ = (saved != seen);
   end else begin : g_part
      logic [ADDR_W-1-CMP_LSB:0] s_hi, n_hi;
      logic [CMP_LSB-1:0]        unused_lo;
      assign s_hi      = saved[ADDR_W-1:CMP_LSB];
      assign n_hi      = seen[ADDR_W-1:CMP_LSB];
      assign unused_lo = saved[CMP_LSB-1:0] ^ seen[CMP_LSB-1:0];
      assign differ    = (s_hi != n_hi);
   end

endmodule

// File: rtl/ret_ctx_stack.sv
module ret_ctx_stack
   import rcs_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MACH_W  = 4,
   parameter int STATE_W = 6,
   parameter int DEPTH   = 8,
   parameter int CMP_LSB = 0,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int ENT_W  = ADDR_W + MACH_W + STATE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic [ADDR_W-1:0]  push_ret_addr_i,
   input  logic [MACH_W-1:0]  push_mach_i,
   input  logic [STATE_W-1:0] push_state_i,
   input  logic               pop_i,
   input  logic [ADDR_W-1:0]  pop_next_pc_i,
   output logic               rst_valid_o,
   output logic [MACH_W-1:0]  rst_mach_o,
   output logic [STATE_W-1:0] rst_state_o,
   output logic               mismatch_o,
   output logic               overflow_o,
   output logic               underflow_o,
   output logic               clash_o,
   output logic               violation_o,
   output logic [CNT_W-1:0]   depth_o
);

   if (DEPTH < 2)                       begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (ADDR_W < 2)                      begin : g_bad_addr  $error("ADDR_W must be at least 2"); end
   if (MACH_W < 1 || STATE_W < 1)       begin : g_bad_ids   $error("ID widths must be positive"); end
   if (CMP_LSB < 0 || CMP_LSB >= ADDR_W) begin : g_bad_lsb  $error("CMP_LSB out of range"); end

   rcs_op_e           op;
   logic              empty, full;
   logic              do_push, do_pop;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  top_idx, wr_idx;
   logic [ENT_W-1:0]  wr_ent, top_ent;
   logic [ADDR_W-1:0] top_addr;
   logic              addr_differ;

   assign op      = rcs_classify(push_i, pop_i);
   assign do_push = (op == RCS_PUSH) && !full;
   assign do_pop  = (op == RCS_POP)  && !empty;

   rcs_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .grow   (do_push),
      .shrink (do_pop),
      .cnt    (cnt),
      .empty  (empty),
      .full   (full)
   );

   assign wr_idx  = IDX_W'(cnt);
   assign top_idx = IDX_W'(cnt - 1'b1);
   assign wr_ent  = {push_ret_addr_i, push_mach_i, push_state_i};

   rcs_store #(.DEPTH(DEPTH), .DATA_W(ENT_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (do_push),
      .wr_idx  (wr_idx),
      .wr_data (wr_ent),
      .rd_idx  (top_idx),
      .rd_data (top_ent)
   );

   assign top_addr    = top_ent[ENT_W-1 -: ADDR_W];
   assign rst_mach_o  = top_ent[STATE_W +: MACH_W];
   assign rst_state_o = top_ent[STATE_W-1:0];

   rcs_cmp #(.ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_cmp (
      .saved  (top_addr),
      .seen   (pop_next_pc_i),
      .differ (addr_differ)
   );

   assign rst_valid_o = do_pop;
   assign mismatch_o  = do_pop && addr_differ;
   assign overflow_o  = (op == RCS_PUSH) && full;
   assign underflow_o = (op == RCS_POP) && empty;
   assign clash_o     = (op == RCS_CLASH);
   assign violation_o = mismatch_o | overflow_o | underflow_o | clash_o;
   assign depth_o     = cnt;

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push_i,
   input logic          pop_i,
   input logic          rst_valid_o,
   input logic          mismatch_o,
   input logic          overflow_o,
   input logic          underflow_o,
   input logic          clash_o,
   input logic          violation_o,
   input logic [CW-1:0] depth_o
);

   a_r1_one_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({overflow_o, underflow_o, clash_o}));

   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && depth_o != CW'(DEPTH)) |=> depth_o == CW'($past(depth_o) + 1'b1));

   a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      rst_valid_o |=> depth_o == CW'($past(depth_o) - 1'b1));

   a_r4_mismatch_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch_o |-> (rst_valid_o && violation_o));

   a_r6_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |-> (depth_o == '0 && !rst_valid_o));

   a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> $stable(depth_o));

   a_r8_clash_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clash_o |=> $stable(depth_o));

endmodule

bind ret_ctx_stack rcs_checker #(.DEPTH(DEPTH)) u_rcs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .rst_valid_o (rst_valid_o),
   .mismatch_o  (mismatch_o),
   .overflow_o  (overflow_o),
   .underflow_o (underflow_o),
   .clash_o     (clash_o),
   .violation_o (violation_o),
   .depth_o     (depth_o)
);

// File: tb/tb_ret_ctx_stack.sv
module tb_ret_ctx_stack;

   localparam int AW = 16, MW = 4, SW = 5, D = 4, CW = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          push, pop;
   logic [AW-1:0] addr, pc;
   logic [MW-1:0] mach;
   logic [SW-1:0] st;

   logic          vld, mis, ovf, unf, clh, vio;
   logic [MW-1:0] rm;
   logic [SW-1:0] rs;
   logic [CW-1:0] dep;
   logic          vld1, mis1, ovf1, unf1, clh1, vio1;
   logic [MW-1:0] rm1;
   logic [SW-1:0] rs1;
   logic [CW-1:0] dep1;

   ret_ctx_stack #(.ADDR_W(AW), .MACH_W(MW), .STATE_W(SW), .DEPTH(D), .CMP_LSB(0)) dut (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_ret_addr_i(addr),
      .push_mach_i(mach), .push_state_i(st), .pop_i(pop), .pop_next_pc_i(pc),
      .rst_valid_o(vld), .rst_mach_o(rm), .rst_state_o(rs), .mismatch_o(mis),
      .overflow_o(ovf), .underflow_o(unf), .clash_o(clh), .violation_o(vio), .depth_o(dep));

   ret_ctx_stack #(.ADDR_W(AW), .MACH_W(MW), .STATE_W(SW), .DEPTH(D), .CMP_LSB(1)) dut_lsb (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_ret_addr_i(addr),
      .push_mach_i(mach), .push_state_i(st), .pop_i(pop), .pop_next_pc_i(pc),
      .rst_valid_o(vld1), .rst_mach_o(rm1), .rst_state_o(rs1), .mismatch_o(mis1),
      .overflow_o(ovf1), .underflow_o(unf1), .clash_o(clh1), .violation_o(vio1), .depth_o(dep1));

   int n_run = 0, n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] f_addr(input int i);
      return AW'(16'h2000 + i * 12 + 4);
   endfunction
   function automatic logic [MW-1:0] f_mach(input int i);
      return MW'(i * 5 + 3);
   endfunction
   function automatic logic [SW-1:0] f_st(input int i);
      return SW'(i * 7 + 1);
   endfunction

   // set inputs on the falling edge, settle, return before the next rising edge
   task automatic drive(input logic pu, input logic po, input int i, input logic [AW-1:0] npc);
      @(negedge clk);
      push = pu; pop = po; pc = npc;
      addr = f_addr(i); mach = f_mach(i); st = f_st(i);
      #4;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 0, '0);
   endtask

   initial begin
      #1_000_000;
      n_run++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      push = 0; pop = 0; addr = '0; pc = '0; mach = '0; st = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();
      // R1 reset state
      chk("R1 depth", 32'(dep), 0);
      chk("R1 flags", {26'd0, vld, mis, ovf, unf, clh, vio}, 0);

      // R6 underflow on empty
      drive(0, 1, 0, '0);
      chk("R6 underflow", {29'd0, unf, vio, vld}, 32'b110);
      idle();
      chk("R6 depth stays 0", 32'(dep), 0);

      // two full fill/drain sweeps: pass 0 matching, pass 1 one flipped bit per level
      for (int pass = 0; pass < 2; pass++) begin
         for (int i = 0; i < D; i++) begin
            drive(1, 0, i, '0);
            chk("R2 no violation on push", 32'(vio), 0);
            idle();
            chk("R2 depth grows", 32'(dep), 32'(i + 1));
         end
         // R7 overflow on full, contents preserved
         drive(1, 0, 9, '0);
         chk("R7 overflow", {30'd0, ovf, vio}, 32'b11);
         idle();
         chk("R7 depth stays full", 32'(dep), D);
         for (int i = D - 1; i >= 0; i--) begin
            logic [AW-1:0] npc;
            npc = (pass == 0) ? f_addr(i) : (f_addr(i) ^ AW'(1 << (i + 2)));
            drive(0, 1, 0, npc);
            chk("R3 restore valid", 32'(vld), 1);
            chk("R3 machine LIFO", 32'(rm), 32'(f_mach(i)));
            chk("R3 state LIFO", 32'(rs), 32'(f_st(i)));
            if (pass == 0) chk("R5 match no mismatch", {30'd0, mis, vio}, 0);
            else           chk("R4 mismatch flagged", {30'd0, mis, vio}, 32'b11);
            idle();
            chk("R3 R4 depth shrinks", 32'(dep), 32'(i));
         end
      end

      // R8 clash at empty, middle and full
      for (int lvl = 0; lvl <= D; lvl += 2) begin
         for (int i = 0; i < lvl; i++) drive(1, 0, i + 20, '0);
         idle();
         drive(1, 1, 30, f_addr(lvl + 19));
         chk("R8 clash", {28'd0, clh, vio, vld, ovf | unf}, 32'b1100);
         idle();
         chk("R8 depth unchanged", 32'(dep), 32'(lvl));
         if (lvl > 0) begin
            drive(0, 1, 0, f_addr(lvl + 19));
            chk("R8 top entry unchanged", {27'd0, mis, rm}, 32'(f_mach(lvl + 19)));
         end
         for (int i = 1; i < lvl; i++) drive(0, 1, 0, '0);
         idle();
         chk("R8 drained", 32'(dep), 0);
      end

      // R9 low bit excluded when CMP_LSB=1
      drive(1, 0, 40, '0);
      drive(1, 0, 41, '0);
      drive(0, 1, 0, f_addr(41) ^ 16'h0001);
      chk("R9 bit0 ignored", 32'(mis1), 0);
      chk("R9 bit0 counts in full compare", 32'(mis), 1);
      drive(0, 1, 0, f_addr(40) ^ 16'h0002);
      chk("R9 bit1 still compared", 32'(mis1), 1);
      idle();
      chk("R9 depth", 32'(dep1), 0);

      // R1 reset empties a loaded stack
      drive(1, 0, 50, '0);
      @(negedge clk) rst_n = 1'b0;
      push = 0;
      @(negedge clk) rst_n = 1'b1;
      idle();
      chk("R1 reset empties", 32'(dep), 0);
      drive(0, 1, 0, '0);
      chk("R1 underflow after reset", 32'(unf), 1);
      idle();

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule